// File: doc/BRIEF.md
# Set/Clear/Toggle Register Bank

The block holds a parameterised number of 32-bit control registers behind a simple synchronous bus slave. Each register owns a 16-byte address window. Inside that window, address bits [3:2] choose how a write changes the register: a full load, a bitwise OR of the write data, a bitwise clear of the bits set in the write data, or a bitwise XOR. Software can therefore flip or set individual control bits in a single bus access, with no read-modify-write sequence and no race against other agents that touch other bits of the same register.

A read at any of the four addresses in a register's window returns that register's current value, one cycle after the request. Only aligned word accesses are accepted. A misaligned address, a byte or halfword size code, or an address past the last register leaves every register untouched and raises a one-cycle error flag.

Top module: `sct_regbank`

## Requirements
- R1: After reset every register reads as zero, and both `bus_err` and `bus_rdata` are zero.
- R2: A legal write with address bits [3:2] = 0 (offset 0x0 in the window) loads the write data into the register.
- R3: A legal write with address bits [3:2] = 1 (offset 0x4) ORs the write data into the register.
- R4: A legal write with address bits [3:2] = 2 (offset 0x8) clears each register bit whose write-data bit is 1.
- R5: A legal write with address bits [3:2] = 3 (offset 0xC) XORs the write data into the register.
- R6: A legal read at any of the four offsets of register k (byte address 16*k + 0x0/0x4/0x8/0xC) returns register k on `bus_rdata` in the cycle after the request.
- R7: When a read and a write to the same register are presented in the same cycle, the read returns the value held before that write.
- R8: An access whose address bits [1:0] are not zero changes no register and raises `bus_err` in the following cycle; such a read returns zero.
- R9: An access with `bus_size` other than 2 (2 = 32-bit word, 0 = byte, 1 = halfword, 3 = reserved) changes no register and raises `bus_err` in the following cycle.
- R10: An access to a register index at or above NUM_REGS changes no register, raises `bus_err` in the following cycle and, for a read, returns zero.
- R11: `bus_err` is high for exactly one cycle per illegal access and is never high after a cycle with no access.
- R12: A write to one register leaves every other register unchanged, and a cycle without a write leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 2 | Access size code, 2 = 32-bit word |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle illegal-access flag |

## Verification
Every result of this block is due exactly one rising edge after the request: a write has changed the register by that edge, and the read data and error flag for a request are registered on that same edge. The scoreboard stamps each expected item with the cycle in which it was driven and compares it only at the falling edge after the next rising edge, so a read issued together with a write is judged against the value before the write. Effects that should be absent are checked by reading the register back through its normal address in a later access.

// File: rtl/sct_pkg.sv
package sct_pkg;

   // write action selected by address bits [3:2]
   typedef enum logic [1:0] {
      SCT_LOAD = 2'd0,
      SCT_SET  = 2'd1,
      SCT_CLR  = 2'd2,
      SCT_FLIP = 2'd3
   } sct_op_e;

   // size code for a full 32-bit access
   localparam logic [1:0] SCT_SIZE_WORD = 2'd2;

   // bytes per register window and number of low address bits it spans
   localparam int SCT_WIN_BYTES = 16;
   localparam int SCT_WIN_BITS  = 4;

   // decoded view of one bus request
   typedef struct packed {
      logic    lane_ok;
      logic    size_ok;
      logic    range_ok;
      sct_op_e op;
   } sct_dec_t;

endpackage

// File: rtl/sct_decode.sv
module sct_decode
   import sct_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int ADDR_W   = 8,
   parameter int IDX_W    = 3
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic [1:0]          size,
   input  logic                wr,
   input  logic                rd,
   output sct_dec_t            dec,
   output logic [IDX_W-1:0]    idx,
   output logic                legal,
   output logic                bad_access,
   output logic [NUM_REGS-1:0] wr_sel
);

   localparam int UPPER_W  = ADDR_W - SCT_WIN_BITS;
   localparam int MAP_REGS = 2 ** UPPER_W;

   logic [UPPER_W-1:0] upper;

   assign upper = addr[ADDR_W-1:SCT_WIN_BITS];

   // when the bank fills the whole address map no index can be out of range
   generate
      if (NUM_REGS == MAP_REGS) begin : g_full_map
         assign dec.range_ok = 1'b1;
      end else begin : g_partial_map
         assign dec.range_ok = (upper < UPPER_W'(NUM_REGS));
      end
   endgenerate

   assign dec.lane_ok = (addr[1:0] == 2'b00);
   assign dec.size_ok = (size == SCT_SIZE_WORD);
   assign dec.op      = sct_op_e'(addr[3:2]);

   generate
      if (UPPER_W >= IDX_W) begin : g_idx_trunc
         assign idx = upper[IDX_W-1:0];
      end else begin : g_idx_pad
         assign idx = IDX_W'(upper);
      end
   endgenerate

   assign legal      = dec.lane_ok & dec.size_ok & dec.range_ok;
   assign bad_access = (wr | rd) & ~legal;

   // one-hot write strobe, one line per register
   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
         assign wr_sel[g] = wr & legal & (idx == IDX_W'(g));
      end
   endgenerate

endmodule

// File: rtl/sct_reg_cell.sv
module sct_reg_cell
   import sct_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  sct_op_e           op,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] nxt;

   always_comb begin
      unique case (op)
         SCT_LOAD: nxt = wdata;
         SCT_SET:  nxt = q | wdata;
         SCT_CLR:  nxt = q & ~wdata;
         SCT_FLIP: nxt = q ^ wdata;
         default:  nxt = q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= nxt;
      end
   end

endmodule

// File: rtl/sct_rdport.sv
module sct_rdport #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd,
   input  logic                       legal,
   input  logic [IDX_W-1:0]           idx,
   input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
   output logic [DATA_W-1:0]          rdata
);

   logic [DATA_W-1:0] word;

   // index is only used when the access is legal, so it is always in range
   always_comb begin
      word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == IDX_W'(i)) begin
            word = regs_flat[i*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         rdata <= legal ? word : '0;
      end
   end

endmodule

// File: rtl/sct_regbank.sv
module sct_regbank
   import sct_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err
);

   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   generate
      if (DATA_W != 32) begin : g_chk_width
         $error("sct_regbank: DATA_W must be 32");
      end
      if (NUM_REGS < 1) begin : g_chk_count
         $error("sct_regbank: NUM_REGS must be at least 1");
      end
      if (ADDR_W <= SCT_WIN_BITS) begin : g_chk_addr
         $error("sct_regbank: ADDR_W too small for one window");
      end else if (NUM_REGS > 2 ** (ADDR_W - SCT_WIN_BITS)) begin : g_chk_fit
         $error("sct_regbank: NUM_REGS windows do not fit in ADDR_W");
      end
   endgenerate

   sct_dec_t                   dec;
   logic [IDX_W-1:0]           idx;
   logic                       legal;
   logic                       bad_access;
   logic [NUM_REGS-1:0]        wr_sel;
   logic [NUM_REGS*DATA_W-1:0] regs_flat;
   logic                       err_q;

   sct_decode #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W)
   ) u_decode (
      .addr       (bus_addr),
      .size       (bus_size),
      .wr         (bus_wr),
      .rd         (bus_rd),
      .dec        (dec),
      .idx        (idx),
      .legal      (legal),
      .bad_access (bad_access),
      .wr_sel     (wr_sel)
   );

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         sct_reg_cell #(
            .DATA_W (DATA_W)
         ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_sel[g]),
            .op    (dec.op),
            .wdata (bus_wdata),
            .q     (regs_flat[g*DATA_W +: DATA_W])
         );
      end
   endgenerate

   sct_rdport #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W)
   ) u_rdport (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd        (bus_rd),
      .legal     (legal),
      .idx       (idx),
      .regs_flat (regs_flat),
      .rdata     (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else begin
         err_q <= bad_access;
      end
   end

   assign bus_err = err_q;

endmodule

// File: rtl/sct_regbank_chk.sv
module sct_regbank_chk #(
   parameter int NUM_REGS = 8,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [1:0]                 bus_size,
   input logic                       bus_wr,
   input logic                       bus_rd,
   input logic [DATA_W-1:0]          bus_rdata,
   input logic                       bus_err,
   input logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   int                unsigned win;
   logic              ok;
   logic [DATA_W-1:0] cur;

   always_comb begin
      win = 32'(bus_addr[ADDR_W-1:4]);
      ok  = (bus_addr[1:0] == 2'b00) && (bus_size == 2'd2) && (win < NUM_REGS);
      cur = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (win == i) cur = regs_flat[i*DATA_W +: DATA_W];
      end
   end

   // R6
   rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ok) |=> (bus_rdata == $past(cur)));

   // R8
   lane_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && bus_addr[1:0] != 2'b00) |=> bus_err);

   // R8
   lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[1:0] != 2'b00) |=> $stable(regs_flat));

   // R9
   size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_size != 2'd2) |=> ($stable(regs_flat) && bus_err));

   // R10
   range_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && win >= NUM_REGS) |=> (bus_err && bus_rdata == '0));

   // R11
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_wr || bus_rd));

   // R11
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && ok) |=> !bus_err);

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(regs_flat));

endmodule

bind sct_regbank sct_regbank_chk #(
   .NUM_REGS (NUM_REGS),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_size  (bus_size),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .regs_flat (regs_flat)
);

// File: tb/sct_regbank_test.sv
module sct_regbank_test;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_REGS   = 8;
   localparam int ADDR_W     = 8;
   localparam int DATA_W     = 32;

   typedef struct {
      int                stamp;
      logic              chk_rd;
      logic [DATA_W-1:0] exp_rdata;
      logic              exp_err;
      string             tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [1:0]        bus_size = 2'd2;
   logic              bus_wr = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic              bus_rd = 1'b0;
   logic [DATA_W-1:0] bus_rdata;
   logic              bus_err;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   item_t sb[$];
   logic [DATA_W-1:0] model [NUM_REGS];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sct_regbank #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err)
   );

   task automatic check(input string tag, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: one bus cycle, expectation computed from the requirements
   task automatic access(input logic wr, input logic rd, input logic [ADDR_W-1:0] a,
                         input logic [1:0] sz, input logic [DATA_W-1:0] d,
                         input string tag);
      item_t it;
      int    k;
      logic  ok;
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_size = sz; bus_wdata = d;
      k  = int'(a[ADDR_W-1:4]);
      ok = (a[1:0] == 2'b00) && (sz == 2'd2) && (k < NUM_REGS);
      it.stamp     = cyc;
      it.chk_rd    = rd;
      it.exp_rdata = (rd && ok) ? model[k] : '0;
      it.exp_err   = (wr || rd) && !ok;
      it.tag       = tag;
      sb.push_back(it);
      if (wr && ok) begin
         case (a[3:2])
            2'd0: model[k] = d;
            2'd1: model[k] = model[k] | d;
            2'd2: model[k] = model[k] & ~d;
            default: model[k] = model[k] ^ d;
         endcase
      end
   endtask

   task automatic idle(input string tag);
      access(1'b0, 1'b0, '0, 2'd2, '0, tag);
   endtask

   task automatic rd_at(input logic [ADDR_W-1:0] a, input string tag);
      access(1'b0, 1'b1, a, 2'd2, '0, tag);
   endtask

   task automatic wr_at(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input string tag);
      access(1'b1, 1'b0, a, 2'd2, d, tag);
   endtask

   // monitor: results are due one rising edge after the driving cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].stamp < cyc) begin
         item_t it;
         it = sb.pop_front();
         check({it.tag, " err"}, DATA_W'(bus_err), DATA_W'(it.exp_err));
         if (it.chk_rd) check({it.tag, " rdata"}, bus_rdata, it.exp_rdata);
      end
   end

   initial begin
      for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: outputs idle after reset
      check("R1 err", DATA_W'(bus_err), '0);
      check("R1 rdata", bus_rdata, '0);
      for (int i = 0; i < NUM_REGS; i++) rd_at(ADDR_W'(i * 16), "R1");

      // R2, R6: load, read back through every alias
      wr_at(8'h20, 32'hA5A5_0F0F, "R2");
      rd_at(8'h20, "R6");
      rd_at(8'h24, "R6");
      rd_at(8'h28, "R6");
      rd_at(8'h2C, "R6");
      // R3
      wr_at(8'h24, 32'h0000_F0F0, "R3");
      rd_at(8'h20, "R3");
      // R4
      wr_at(8'h28, 32'hA500_00FF, "R4");
      rd_at(8'h20, "R4");
      // R5
      wr_at(8'h2C, 32'hFFFF_0000, "R5");
      rd_at(8'h20, "R5");

      // R7: read and write together return the old value
      access(1'b1, 1'b1, 8'h20, 2'd2, 32'h1234_5678, "R7");
      rd_at(8'h2C, "R7");
      access(1'b1, 1'b1, 8'h2C, 2'd2, 32'hFFFF_FFFF, "R7");
      rd_at(8'h20, "R7");

      // R8: misaligned write and read
      wr_at(8'h21, 32'hFFFF_FFFF, "R8");
      rd_at(8'h20, "R8");
      rd_at(8'h26, "R8");
      // R11: flag drops on an idle cycle after an error
      idle("R11");
      idle("R11");

      // R9: byte, halfword and reserved sizes
      access(1'b1, 1'b0, 8'h20, 2'd0, 32'h0, "R9");
      access(1'b1, 1'b0, 8'h24, 2'd1, 32'hFFFF_FFFF, "R9");
      access(1'b1, 1'b1, 8'h2C, 2'd3, 32'hFFFF_FFFF, "R9");
      rd_at(8'h20, "R9");

      // R10: windows past the last register
      wr_at(8'h90, 32'hDEAD_BEEF, "R10");
      rd_at(8'h90, "R10");
      wr_at(8'hF4, 32'hFFFF_FFFF, "R10");
      for (int i = 0; i < NUM_REGS; i++) rd_at(ADDR_W'(i * 16), "R10");

      // R12: independent registers, including the last one
      wr_at(8'h00, 32'h0000_0001, "R12");
      wr_at(8'h70, 32'h8000_0000, "R12");
      wr_at(8'h74, 32'h0000_00F0, "R12");
      idle("R12");
      for (int i = 0; i < NUM_REGS; i++) rd_at(ADDR_W'(i * 16 + 4 * (i % 4)), "R12");

      // R11: error followed directly by a legal access
      rd_at(8'h13, "R11");
      rd_at(8'h10, "R11");
      idle("R11");
      idle("R11");
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule